// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to normal operation. A one-cycle `start_i` pulse launches a fixed list of fourteen commands. Each command appears on a narrow command interface for a single clock cycle, together with a bank-address value. While the sequence runs, three level flags describe the memory state: clock-enable, DLL reset, and OCD default drive.

Every pause between two commands comes from a time in nanoseconds, converted to clock cycles from the `CLK_MHZ` parameter. The one exception is the DLL lock pause, which is a plain cycle count. A single down-counter, wide enough for the 200 µs power-up pause at the fastest supported clock, times all of the pauses.

After the final normal-mode command, `done_o` rises and stays high. At the same moment `refresh_load_o` pulses once, so the controller can load its refresh-interval count. The memory controller that owns the physical interface listens to these outputs and turns each strobe into real bus activity.

Top module: `ddr2_init_seq`

## Requirements
- R1: While synchronous reset is high, and afterwards until `start_i` is seen, all of these outputs are 0: `cmd_valid_o`, `cmd_o`, `bank_o`, `cke_o`, `dll_rst_o`, `ocd_dflt_o`, `done_o`, `refresh_load_o`.
- R2: After `start_i`, exactly fourteen commands are emitted, given as (command, bank): (0,0) (0,0) (1,0) (3,2) (3,3) (3,1) (2,0) (1,0) (4,0) (4,0) (2,0) (3,1) (3,1) (5,0). The codes are NOP=0, precharge-all=1, MRS=2, EMRS=3, auto-refresh=4, normal=5.
- R3: `cmd_valid_o` is high for exactly one cycle per command. The first command appears in the cycle right after the cycle in which `start_i` was sampled high.
- R4: Command k+1 comes W cycles after command k. W = max(2, ceil(t·CLK_MHZ/1000)), where t depends on command k:
  - 200000 ns after the first NOP;
  - 400 ns after the second NOP;
  - 400 ns after the second precharge-all;
  - 400 ns after each auto-refresh;
  - 15 ns after every other command.
  - The exception is the pause after the EMRS to bank 1 at step 6, which is max(DLL_LOCK_CYC, 15 ns worth of cycles).
- R5: `cke_o` is 0 during the first NOP and its pause. It is 1 from the second NOP onward, through `done_o`.
- R6: `dll_rst_o` is 1 from the first MRS through both auto-refreshes. It is 0 at every other command, including the second MRS.
- R7: `ocd_dflt_o` is 1 only at the first of the two final EMRS commands to bank 1, and during the pause after it.
- R8: `done_o` rises one cycle after the normal-mode command and then stays high. `refresh_load_o` is high only in that first done cycle.
- R9: `start_i` has no effect while the sequence runs or after `done_o` is high. The timing and command stream are unchanged, and no further commands appear.
- R10: A reset in the middle of the sequence returns all outputs to the idle values. A later `start_i` then runs the complete sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse; honoured only when idle |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 3 | Command code (0 when no strobe) |
| bank_o | output | 2 | Bank address for the command (0 when no strobe) |
| cke_o | output | 1 | Clock-enable level for the memory |
| dll_rst_o | output | 1 | DLL reset bit for mode-register data |
| ocd_dflt_o | output | 1 | OCD default bit for extended-mode data |
| done_o | output | 1 | Initialization complete |
| refresh_load_o | output | 1 | One-cycle pulse to load the refresh interval |

## Verification
The bench runs the full sequence three ways:
- undisturbed;
- with a stray start pulse inside the 200 µs pause;
- after a reset that aborts a run partway, once CKE is already high.

Each run measures the exact cycle gap before every command. It also checks the code, bank and three flags at each strobe. These checks separate correct timing from off-by-one counter loads, and a correct command order from swapped bank addresses. The aborted run shows that reset clears CKE and the step index. The stray start shows that a busy sequencer does not restart. A start pulse after completion then checks that the done state is sticky.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

    localparam int BA_W    = 2;
    localparam int NSTEPS  = 14;
    localparam int STEP_W  = $clog2(NSTEPS);

    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_PREA   = 3'd1,
        CMD_MRS    = 3'd2,
        CMD_EMRS   = 3'd3,
        CMD_REF    = 3'd4,
        CMD_NORMAL = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        WT_PWRUP,
        WT_CKE,
        WT_MRD,
        WT_DLL,
        WT_PRE,
        WT_RFC,
        WT_NONE
    } wait_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;

    typedef struct packed {
        cmd_e            cmd;
        logic [BA_W-1:0] bank;
        wait_e           wsel;
        logic            cke;
        logic            dll;
        logic            ocd;
    } step_t;

    // Nanoseconds to cycles, rounded up, never below two cycles.
    function automatic int unsigned ns_to_cycles(int unsigned ns, int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic step_t step_lookup(logic [STEP_W-1:0] s);
        step_t r;
        r = '{cmd: CMD_NOP, bank: '0, wsel: WT_NONE, cke: 1'b1, dll: 1'b0, ocd: 1'b0};
        case (s)
            4'd0:  begin r.cmd = CMD_NOP;    r.wsel = WT_PWRUP; r.cke = 1'b0; end
            4'd1:  begin r.cmd = CMD_NOP;    r.wsel = WT_CKE;   end
            4'd2:  begin r.cmd = CMD_PREA;   r.wsel = WT_MRD;   end
            4'd3:  begin r.cmd = CMD_EMRS;   r.bank = 2'd2; r.wsel = WT_MRD; end
            4'd4:  begin r.cmd = CMD_EMRS;   r.bank = 2'd3; r.wsel = WT_MRD; end
            4'd5:  begin r.cmd = CMD_EMRS;   r.bank = 2'd1; r.wsel = WT_DLL; end
            4'd6:  begin r.cmd = CMD_MRS;    r.wsel = WT_MRD;   r.dll = 1'b1; end
            4'd7:  begin r.cmd = CMD_PREA;   r.wsel = WT_PRE;   r.dll = 1'b1; end
            4'd8:  begin r.cmd = CMD_REF;    r.wsel = WT_RFC;   r.dll = 1'b1; end
            4'd9:  begin r.cmd = CMD_REF;    r.wsel = WT_RFC;   r.dll = 1'b1; end
            4'd10: begin r.cmd = CMD_MRS;    r.wsel = WT_MRD;   end
            4'd11: begin r.cmd = CMD_EMRS;   r.bank = 2'd1; r.wsel = WT_MRD; r.ocd = 1'b1; end
            4'd12: begin r.cmd = CMD_EMRS;   r.bank = 2'd1; r.wsel = WT_MRD; end
            default: begin r.cmd = CMD_NORMAL; r.wsel = WT_NONE; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
`timescale 1ns/1ps
module ddr2_init_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_steps.sv
`timescale 1ns/1ps
module ddr2_init_steps
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 250,
    parameter int unsigned T_PWRUP_NS   = 200000,
    parameter int unsigned T_CKE_NS     = 400,
    parameter int unsigned T_MRD_NS     = 15,
    parameter int unsigned T_PRE_NS     = 400,
    parameter int unsigned T_RFC_NS     = 400,
    parameter int unsigned DLL_LOCK_CYC = 200,
    parameter int          CNT_W        = 16
) (
    input  logic [STEP_W-1:0] step,
    output step_t             info,
    output logic [CNT_W-1:0]  reload
);
    localparam int unsigned C_PWRUP = ns_to_cycles(T_PWRUP_NS, CLK_MHZ);
    localparam int unsigned C_CKE   = ns_to_cycles(T_CKE_NS, CLK_MHZ);
    localparam int unsigned C_MRD   = ns_to_cycles(T_MRD_NS, CLK_MHZ);
    localparam int unsigned C_PRE   = ns_to_cycles(T_PRE_NS, CLK_MHZ);
    localparam int unsigned C_RFC   = ns_to_cycles(T_RFC_NS, CLK_MHZ);
    localparam int unsigned C_DLL   = (DLL_LOCK_CYC > C_MRD) ? DLL_LOCK_CYC : C_MRD;

    int unsigned gap;

    always_comb begin
        info = step_lookup(step);
        case (info.wsel)
            WT_PWRUP: gap = C_PWRUP;
            WT_CKE:   gap = C_CKE;
            WT_MRD:   gap = C_MRD;
            WT_DLL:   gap = C_DLL;
            WT_PRE:   gap = C_PRE;
            WT_RFC:   gap = C_RFC;
            default:  gap = 2;
        endcase
        // The issue cycle and the final compare cycle account for two.
        reload = CNT_W'(gap - 2);
    end
endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
    import ddr2_init_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 250,
    parameter int unsigned MAX_CLK_MHZ  = 533,
    parameter int unsigned T_PWRUP_NS   = 200000,
    parameter int unsigned T_CKE_NS     = 400,
    parameter int unsigned T_MRD_NS     = 15,
    parameter int unsigned T_PRE_NS     = 400,
    parameter int unsigned T_RFC_NS     = 400,
    parameter int unsigned DLL_LOCK_CYC = 200
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    output logic        cmd_valid_o,
    output logic [2:0]  cmd_o,
    output logic [1:0]  bank_o,
    output logic        cke_o,
    output logic        dll_rst_o,
    output logic        ocd_dflt_o,
    output logic        done_o,
    output logic        refresh_load_o
);
    localparam int unsigned MAX_WAIT = ns_to_cycles(T_PWRUP_NS, MAX_CLK_MHZ);
    localparam int          CNT_W    = $clog2(MAX_WAIT + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEPS - 1);

    state_e            st_q;
    logic [STEP_W-1:0] step_q;
    logic              rl_q;
    step_t             info;
    logic [CNT_W-1:0]  reload;
    logic              expired;
    logic              active;

    ddr2_init_steps #(
        .CLK_MHZ      (CLK_MHZ),
        .T_PWRUP_NS   (T_PWRUP_NS),
        .T_CKE_NS     (T_CKE_NS),
        .T_MRD_NS     (T_MRD_NS),
        .T_PRE_NS     (T_PRE_NS),
        .T_RFC_NS     (T_RFC_NS),
        .DLL_LOCK_CYC (DLL_LOCK_CYC),
        .CNT_W        (CNT_W)
    ) u_steps (
        .step   (step_q),
        .info   (info),
        .reload (reload)
    );

    ddr2_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (st_q == ST_ISSUE),
        .load_val (reload),
        .expired  (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            step_q <= '0;
            rl_q   <= 1'b0;
        end else begin
            rl_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q   <= ST_ISSUE;
                    step_q <= '0;
                end
                ST_ISSUE: if (step_q == LAST_STEP) begin
                    st_q <= ST_DONE;
                    rl_q <= 1'b1;
                end else begin
                    st_q <= ST_WAIT;
                end
                ST_WAIT: if (expired) begin
                    st_q   <= ST_ISSUE;
                    step_q <= step_q + 1'b1;
                end
                default: st_q <= ST_DONE;
            endcase
        end
    end

    assign active         = (st_q == ST_ISSUE) || (st_q == ST_WAIT);
    assign cmd_valid_o    = (st_q == ST_ISSUE);
    assign cmd_o          = cmd_valid_o ? info.cmd  : 3'd0;
    assign bank_o         = cmd_valid_o ? info.bank : 2'd0;
    assign cke_o          = active ? info.cke : (st_q == ST_DONE);
    assign dll_rst_o      = active & info.dll;
    assign ocd_dflt_o     = active & info.ocd;
    assign done_o         = (st_q == ST_DONE);
    assign refresh_load_o = rl_q;
endmodule

// File: rtl/ddr2_init_chk.sv
`timescale 1ns/1ps
module ddr2_init_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid_o,
    input logic [2:0] cmd_o,
    input logic       cke_o,
    input logic       dll_rst_o,
    input logic       ocd_dflt_o,
    input logic       done_o,
    input logic       refresh_load_o
);
    // R3: a strobe never lasts two cycles
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

    // R5: once raised, CKE stays high until reset
    a_r5_cke_sticky: assert property (@(posedge clk) disable iff (rst)
        cke_o |=> cke_o);

    // R8: done is sticky and silences the command port
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (done_o && !cmd_valid_o));

    // R8: refresh load pulse only with done, one cycle wide
    a_r8_refresh_pulse: assert property (@(posedge clk) disable iff (rst)
        refresh_load_o |-> (done_o && $rose(done_o)));

    // R6/R7: the two flags never overlap
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dll_rst_o && ocd_dflt_o));

    // R2: the normal-mode command is the last strobe before done
    a_r2_normal_then_done: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_o && cmd_o == 3'd5) |=> done_o);
endmodule

bind ddr2_init_seq ddr2_init_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_o          (cmd_o),
    .cke_o          (cke_o),
    .dll_rst_o      (dll_rst_o),
    .ocd_dflt_o     (ocd_dflt_o),
    .done_o         (done_o),
    .refresh_load_o (refresh_load_o)
);

// File: tb/sim_ddr2_init_seq.sv
`timescale 1ns/1ps
module sim_ddr2_init_seq;
    localparam int MHZ = 250;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cmd_valid;
    logic [2:0] cmd;
    logic [1:0] bank;
    logic       cke, dll, ocd, done, rload;

    int n_chk  = 0;
    int n_fail = 0;

    int e_cmd  [14];
    int e_bank [14];
    int e_gap  [14];
    int e_cke  [14];
    int e_dll  [14];
    int e_ocd  [14];

    always #2 clk = ~clk;

    ddr2_init_seq #(.CLK_MHZ(MHZ)) u0 (
        .clk(clk), .rst(rst), .start_i(start),
        .cmd_valid_o(cmd_valid), .cmd_o(cmd), .bank_o(bank),
        .cke_o(cke), .dll_rst_o(dll), .ocd_dflt_o(ocd),
        .done_o(done), .refresh_load_o(rload)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cy(input int ns);
        int c;
        c = (ns * MHZ + 999) / 1000;
        return (c < 2) ? 2 : c;
    endfunction

    task automatic check_idle(input string req);
        chk(cmd_valid == 0, req, cmd_valid, 0);
        chk(cmd == 0 && bank == 0, req, {cmd, bank}, 0);
        chk(cke == 0, req, cke, 0);
        chk(dll == 0 && ocd == 0, req, {dll, ocd}, 0);
        chk(done == 0 && rload == 0, req, {done, rload}, 0);
    endtask

    // Drives start, then checks every strobe of one full run.
    task automatic run_seq(input bit poke);
        int idx = 0;
        int cyc = 0;
        int last = 0;
        int gap1 = -1;
        bit prev_v = 0;
        @(negedge clk);
        start = 1'b1;
        while (idx < 14 && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 5000);
            if (prev_v && cmd_valid) chk(0, "R3 double strobe", 1, 0);
            if (cmd_valid) begin
                int g;
                g = cyc - last;
                if (idx == 0) chk(g == 1, "R3 first cmd delay", g, 1);
                else chk(g == e_gap[idx-1], "R4 gap", g, e_gap[idx-1]);
                if (idx == 1) gap1 = g;
                chk(int'(cmd) == e_cmd[idx], "R2 cmd", cmd, e_cmd[idx]);
                chk(int'(bank) == e_bank[idx], "R2 bank", bank, e_bank[idx]);
                chk(int'(cke) == e_cke[idx], "R5 cke", cke, e_cke[idx]);
                chk(int'(dll) == e_dll[idx], "R6 dll reset", dll, e_dll[idx]);
                chk(int'(ocd) == e_ocd[idx], "R7 ocd default", ocd, e_ocd[idx]);
                chk(done == 0, "R8 early done", done, 0);
                last = cyc;
                idx++;
            end
            prev_v = cmd_valid;
        end
        chk(idx == 14, "R2 command count", idx, 14);
        if (poke) chk(gap1 == e_gap[0], "R9 start during wait", gap1, e_gap[0]);
        @(negedge clk);
        chk(cmd_valid == 0, "R3 strobe width", cmd_valid, 0);
        chk(done == 1, "R8 done after normal", done, 1);
        chk(rload == 1, "R8 refresh load", rload, 1);
        @(negedge clk);
        chk(rload == 0, "R8 refresh load width", rload, 0);
        chk(done == 1 && cke == 1, "R8 done held", {done, cke}, 3);
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        e_cmd  = '{0, 0, 1, 3, 3, 3, 2, 1, 4, 4, 2, 3, 3, 5};
        e_bank = '{0, 0, 0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1, 0};
        e_cke  = '{0, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1};
        e_dll  = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0};
        e_ocd  = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
        e_gap[0]  = cy(200000);
        e_gap[1]  = cy(400);
        e_gap[2]  = cy(15);
        e_gap[3]  = cy(15);
        e_gap[4]  = cy(15);
        e_gap[5]  = (200 > cy(15)) ? 200 : cy(15);
        e_gap[6]  = cy(15);
        e_gap[7]  = cy(400);
        e_gap[8]  = cy(400);
        e_gap[9]  = cy(400);
        e_gap[10] = cy(15);
        e_gap[11] = cy(15);
        e_gap[12] = cy(15);
        e_gap[13] = 0;

        repeat (4) @(negedge clk);
        check_idle("R1 in reset");
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check_idle("R1 idle after reset");

        // Run with a stray start inside the power-up pause
        run_seq(1'b1);

        // R9: start after done is ignored
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (cmd_valid) seen++;
            end
            chk(seen == 0, "R9 start after done", seen, 0);
            chk(done == 1, "R9 done kept", done, 1);
        end

        // R10: abort mid-sequence once CKE is high
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (e_gap[0] + 20) @(negedge clk);
        chk(cke == 1, "R10 cke high before abort", cke, 1);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R10 reset mid sequence");
        rst = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (cmd_valid || cke) seen++;
            end
            chk(seen == 0, "R10 stays idle", seen, 0);
        end
        run_seq(1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule